// File: doc/BRIEF.md
# Video RAM DMA Engine

This block carries out the block moves of a tile-based video processor. It has three modes. A transfer reads 16-bit words from main memory and writes them to video RAM, colour RAM or vertical-scroll RAM. A fill writes one byte value over a run of video RAM bytes. A copy moves bytes from one video RAM location to another. Each step reads one source, writes one destination location, advances the source and length counters and adds the auto-increment value to the destination address.

A control interface loads the source, length, destination, increment, mode and target in one start pulse. A fill then waits, and is not busy, until the CPU writes the data port. The high byte of that write becomes the fill value. Main-memory reads use a request/acknowledge handshake, and `en_i` sets the step rate. The video RAM read port has an asynchronous read: the address goes out and the word comes back in the same cycle. All destination writes leave through one byte-lane write port, and the same cycle's clock edge commits them.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset `busy_o`, `mem_req_o` and `wr_o` are 0.
- R2: `start_i` is accepted only while the engine is idle and `mode_i` is 0 (transfer), 1 (fill) or 2 (copy). A start pulse that arrives while a DMA is running or waiting changes nothing in that DMA's writes.
- R3: A transfer reads main-memory byte address {`src_hi_i`, source pointer, 0}. After each step the 16-bit source pointer `src_lo_i` increments and wraps from 0xFFFF to 0x0000. The high source byte never changes.
- R4: `mem_req_o` rises only after a cycle in which `en_i` was 1. Once raised, it stays high until the first cycle with `mem_ack_i`, which is the cycle in which the transfer step completes.
- R5: A transfer to video RAM (`tgt_i`=0) or vertical-scroll RAM (`tgt_i`=2) writes the whole word (`wr_be_o`=2'b11). The word is byte-swapped only for video RAM at an odd destination address.
- R6: A transfer to colour RAM (`tgt_i`=1) writes unswapped words. The step whose destination address exceeds 0x7F writes nothing and ends the DMA.
- R7: After a fill start, `busy_o` stays 0 and nothing is written until `dport_we_i`. That write stores `dport_byte_i` as the fill value and writes it once at the start address: into the high lane (`wr_be_o`=2'b10) when the address is even, into the low lane (2'b01) when it is odd. The destination address does not advance.
- R8: Each fill step writes the fill value into the low lane for an even destination and into the high lane for an odd one. Both bytes of `wr_data_o` carry the value.
- R9: A copy presents the source byte address on `vram_raddr_o`. It takes the high byte of `vram_rdata_i` when that address is even and the low byte when it is odd. It writes that byte to the high lane for an even destination and to the low lane for an odd one, with the byte on both halves of `wr_data_o`.
- R10: The write address starts at `dst_i` and grows by `inc_i`, modulo 2^16, after every step.
- R11: A nonzero length N gives exactly N steps, with the low length byte borrowing from the high byte, and then the engine goes idle.
- R12: `busy_o` is 1 while a transfer, an active fill or a copy is running, and 0 when idle or waiting for fill data.
- R13: While `en_i` is 0, no fill or copy step takes place and no new main-memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable |
| start_i | input | 1 | Start pulse, taken when idle |
| mode_i | input | 2 | 0 transfer, 1 fill, 2 copy |
| tgt_i | input | 2 | Transfer target: 0 video RAM, 1 colour RAM, 2 scroll RAM |
| src_lo_i | input | 16 | Source pointer (word index for transfer, byte address for copy) |
| src_hi_i | input | 8 | Fixed high source byte for transfer |
| len_i | input | 16 | Step count |
| dst_i | input | 16 | Destination byte address |
| inc_i | input | 8 | Destination auto-increment |
| dport_we_i | input | 1 | Data-port write strobe |
| dport_byte_i | input | 8 | High byte of the data-port write |
| mem_req_o | output | 1 | Main-memory read request |
| mem_addr_o | output | 25 | Main-memory byte address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |
| vram_raddr_o | output | 16 | Copy source byte address |
| vram_rdata_i | input | 16 | Video RAM word at that address |
| wr_o | output | 1 | Destination write strobe |
| wr_tgt_o | output | 2 | Destination memory, same code as `tgt_i` |
| wr_addr_o | output | 16 | Destination byte address |
| wr_data_o | output | 16 | Write data |
| wr_be_o | output | 2 | Lane enables, bit 1 high byte |
| busy_o | output | 1 | DMA running |

## Verification
The bench builds the engine with its default parameters: 8-bit register bytes, a 16-bit destination address and a colour RAM limit of 0x7F. With these values, a transfer starting at source pointer 0xFFFE wraps within four steps, and a colour RAM run starting at 0x78 with stride 4 crosses the limit on its third step. A copy of length 0x0102 forces the low length byte to borrow after two steps and then runs 256 more. Throttled enables and a two-cycle memory latency exercise the wait between request and acknowledge.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_FWAIT,
    ST_FILL,
    ST_COPY
  } dma_state_e;

  localparam logic [1:0] MODE_XFER = 2'd0;
  localparam logic [1:0] MODE_FILL = 2'd1;
  localparam logic [1:0] MODE_COPY = 2'd2;

  localparam logic [1:0] TGT_VRAM  = 2'd0;
  localparam logic [1:0] TGT_CRAM  = 2'd1;
  localparam logic [1:0] TGT_VSRAM = 2'd2;
endpackage

// File: rtl/dma_src_ptr.sv
module dma_src_ptr #(
  parameter int REG_BW = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [2*REG_BW-1:0]   lo_i,
  input  logic [REG_BW-1:0]     hi_i,
  input  logic                  adv_i,
  output logic [2*REG_BW-1:0]   lo_o,
  output logic [REG_BW-1:0]     hi_o
);
  localparam int LW = 2 * REG_BW;

  logic [LW-1:0]     lo_q;
  logic [REG_BW-1:0] hi_q;

  // carry stops at the two low bytes; high byte is load-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      lo_q <= lo_i;
      hi_q <= hi_i;
    end else if (adv_i) begin
      lo_q <= lo_q + LW'(1);
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  assert_hi_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hi_q));
endmodule

// File: rtl/dma_len_cnt.sv
module dma_len_cnt #(
  parameter int REG_BW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2*REG_BW-1:0] len_i,
  input  logic                dec_i,
  output logic                last_o
);
  logic [REG_BW-1:0] lo_q, hi_q, lo_n, hi_n;

  always_comb begin
    lo_n = lo_q - REG_BW'(1);
    hi_n = (lo_q == '0) ? hi_q - REG_BW'(1) : hi_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      lo_q <= len_i[REG_BW-1:0];
      hi_q <= len_i[2*REG_BW-1:REG_BW];
    end else if (dec_i) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign last_o = (lo_n == '0) && (hi_n == '0);

  assert_borrow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && lo_q == '0) |=> hi_q == REG_BW'($past(hi_q) - REG_BW'(1)));
  assert_lo_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> lo_q != $past(lo_q));
endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   word_i,
  input  logic            swap_i,
  input  logic            byte_mode_i,
  input  logic [DW/2-1:0] byte_i,
  input  logic            hi_lane_i,
  output logic [DW-1:0]   data_o,
  output logic [1:0]      be_o
);
  localparam int BW = DW / 2;

  always_comb begin
    if (byte_mode_i) begin
      data_o = {byte_i, byte_i};
      be_o   = hi_lane_i ? 2'b10 : 2'b01;
    end else begin
      data_o = swap_i ? {word_i[BW-1:0], word_i[DW-1:BW]} : word_i;
      be_o   = 2'b11;
    end
  end
endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
  import dma_pkg::*;
#(
  parameter int                REG_BW   = 8,
  parameter int                DST_AW   = 16,
  parameter logic [DST_AW-1:0] CRAM_MAX = 'h7F
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          tgt_i,
  input  logic [2*REG_BW-1:0] src_lo_i,
  input  logic [REG_BW-1:0]   src_hi_i,
  input  logic [2*REG_BW-1:0] len_i,
  input  logic [DST_AW-1:0]   dst_i,
  input  logic [REG_BW-1:0]   inc_i,
  input  logic                dport_we_i,
  input  logic [REG_BW-1:0]   dport_byte_i,
  output logic                mem_req_o,
  output logic [3*REG_BW:0]   mem_addr_o,
  input  logic                mem_ack_i,
  input  logic [2*REG_BW-1:0] mem_rdata_i,
  output logic [2*REG_BW-1:0] vram_raddr_o,
  input  logic [2*REG_BW-1:0] vram_rdata_i,
  output logic                wr_o,
  output logic [1:0]          wr_tgt_o,
  output logic [DST_AW-1:0]   wr_addr_o,
  output logic [2*REG_BW-1:0] wr_data_o,
  output logic [1:0]          wr_be_o,
  output logic                busy_o
);
  localparam int DW = 2 * REG_BW;

  dma_state_e        state_q, state_d;
  logic              pend_q;
  logic [1:0]        tgt_q;
  logic [DST_AW-1:0] dst_q;
  logic [REG_BW-1:0] inc_q, fill_q;
  logic              busy_q;

  logic [DW-1:0]     src_lo;
  logic [REG_BW-1:0] src_hi;
  logic              len_last;

  logic accept, issue, xfer_done, cram_abort;
  logic step_x, step_f, step_c, step, arm;
  logic [REG_BW-1:0] copy_byte, lane_byte;

  always_comb begin
    accept     = start_i && (state_q == ST_IDLE) && (mode_i != 2'd3);
    issue      = (state_q == ST_XFER) && !pend_q && en_i;
    xfer_done  = (state_q == ST_XFER) && pend_q && mem_ack_i;
    cram_abort = xfer_done && (tgt_q == TGT_CRAM) && (dst_q > CRAM_MAX);
    step_x     = xfer_done && !cram_abort;
    step_f     = (state_q == ST_FILL) && en_i;
    step_c     = (state_q == ST_COPY) && en_i;
    step       = step_x || step_f || step_c;
    arm        = (state_q == ST_FWAIT) && dport_we_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        unique case (mode_i)
          MODE_XFER: state_d = ST_XFER;
          MODE_FILL: state_d = ST_FWAIT;
          default:   state_d = ST_COPY;
        endcase
      end
      ST_XFER: if (cram_abort || (step_x && len_last)) state_d = ST_IDLE;
      ST_FWAIT: if (arm) state_d = ST_FILL;
      ST_FILL, ST_COPY: if (step && len_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      tgt_q   <= TGT_VRAM;
      dst_q   <= '0;
      inc_q   <= '0;
      fill_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d == ST_XFER) || (state_d == ST_FILL) || (state_d == ST_COPY);
      if (accept) pend_q <= 1'b0;
      else if (issue) pend_q <= 1'b1;
      else if (xfer_done) pend_q <= 1'b0;
      if (accept) begin
        tgt_q <= tgt_i;
        inc_q <= inc_i;
        dst_q <= dst_i;
      end else if (step) begin
        dst_q <= dst_q + DST_AW'(inc_q);
      end
      if (arm) fill_q <= dport_byte_i;
    end
  end

  dma_src_ptr #(.REG_BW(REG_BW)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .lo_i   (src_lo_i),
    .hi_i   (src_hi_i),
    .adv_i  (step_x || step_c),
    .lo_o   (src_lo),
    .hi_o   (src_hi)
  );

  dma_len_cnt #(.REG_BW(REG_BW)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .len_i  (len_i),
    .dec_i  (step),
    .last_o (len_last)
  );

  // copy source: even byte address holds the high byte of the word
  assign copy_byte = src_lo[0] ? vram_rdata_i[REG_BW-1:0] : vram_rdata_i[DW-1:REG_BW];

  always_comb begin
    if (arm)                      lane_byte = dport_byte_i;
    else if (state_q == ST_FILL)  lane_byte = fill_q;
    else                          lane_byte = copy_byte;
  end

  dma_lane_pack #(.DW(DW)) u_pack (
    .word_i      (mem_rdata_i),
    .swap_i      ((tgt_q == TGT_VRAM) && dst_q[0]),
    .byte_mode_i (state_q != ST_XFER),
    .byte_i      (lane_byte),
    .hi_lane_i   ((state_q == ST_FILL) ? dst_q[0] : ~dst_q[0]),
    .data_o      (wr_data_o),
    .be_o        (wr_be_o)
  );

  assign wr_o         = step || arm;
  assign wr_tgt_o     = (state_q == ST_XFER) ? tgt_q : TGT_VRAM;
  assign wr_addr_o    = dst_q;
  assign mem_req_o    = pend_q;
  assign mem_addr_o   = {src_hi, src_lo, 1'b0};
  assign vram_raddr_o = src_lo;
  assign busy_o       = busy_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!wr_o && !mem_req_o));
  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o);
  assert_cram_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && wr_tgt_o == TGT_CRAM) |-> (wr_addr_o <= CRAM_MAX));
  assert_wait_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FWAIT && !dport_we_i) |-> (!wr_o && !busy_o));
  assert_one_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && state_q != ST_XFER) |-> ($countones(wr_be_o) == 1));
  assert_gate_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && (state_q == ST_FILL || state_q == ST_COPY)) |-> !wr_o);
endmodule

// File: tb/tb_vram_dma_engine.sv
module tb_vram_dma_engine;
  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  tgt;
    logic [7:0]  src_hi;
    logic [15:0] src_lo;
    logic [15:0] len;
    logic [15:0] dst;
    logic [7:0]  inc;
    logic [7:0]  fbyte;
    logic [1:0]  enm;
    logic        restart;
  } scen_t;

  // mode tgt src_hi src_lo len dst inc fbyte enm restart
  localparam int NS = 8;
  localparam scen_t SCN [NS] = '{
    '{2'd0, 2'd0, 8'h12, 16'h0100, 16'd5,     16'h0000, 8'd2, 8'h00, 2'd0, 1'b1},
    '{2'd0, 2'd0, 8'h03, 16'h0020, 16'd4,     16'h0101, 8'd2, 8'h00, 2'd1, 1'b0},
    '{2'd0, 2'd2, 8'h7E, 16'hFFFE, 16'd4,     16'h0010, 8'd2, 8'h00, 2'd1, 1'b0},
    '{2'd0, 2'd1, 8'h00, 16'h0040, 16'd6,     16'h0078, 8'd4, 8'h00, 2'd0, 1'b0},
    '{2'd1, 2'd0, 8'h00, 16'h0000, 16'd4,     16'h0200, 8'd1, 8'hA7, 2'd0, 1'b0},
    '{2'd1, 2'd0, 8'h00, 16'h0000, 16'd3,     16'h0301, 8'd2, 8'h3C, 2'd1, 1'b0},
    '{2'd2, 2'd0, 8'h00, 16'h0041, 16'd6,     16'h0400, 8'd1, 8'h00, 2'd0, 1'b0},
    '{2'd2, 2'd0, 8'h00, 16'h0000, 16'h0102,  16'h1000, 8'd1, 8'h00, 2'd0, 1'b0}
  };

  logic        clk = 0, rst_n = 0;
  logic        en_i = 0, start_i = 0, dport_we_i = 0, mem_ack_i = 0;
  logic [1:0]  mode_i = 0, tgt_i = 0;
  logic [15:0] src_lo_i = 0, len_i = 0, dst_i = 0, mem_rdata_i = 0, vram_rdata_i;
  logic [7:0]  src_hi_i = 0, inc_i = 0, dport_byte_i = 0;
  logic        mem_req_o, wr_o, busy_o;
  logic [24:0] mem_addr_o;
  logic [15:0] vram_raddr_o, wr_addr_o, wr_data_o;
  logic [1:0]  wr_tgt_o, wr_be_o;

  int n_chk = 0, n_fail = 0, cyc = 0, viol = 0, cap_n = 0;
  int en_mode = 0;
  logic [1:0] lat = 0;
  bit cap_on = 0, p_req = 0, p_ack = 0, p_en = 0;
  logic [15:0] cap_addr [512], cap_data [512];
  logic [1:0]  cap_be [512], cap_tgt [512];
  logic [24:0] cap_ma [512];

  vram_dma_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .start_i(start_i), .mode_i(mode_i),
    .tgt_i(tgt_i), .src_lo_i(src_lo_i), .src_hi_i(src_hi_i), .len_i(len_i),
    .dst_i(dst_i), .inc_i(inc_i), .dport_we_i(dport_we_i), .dport_byte_i(dport_byte_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .vram_raddr_o(vram_raddr_o), .vram_rdata_i(vram_rdata_i),
    .wr_o(wr_o), .wr_tgt_o(wr_tgt_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_be_o(wr_be_o), .busy_o(busy_o)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] memf(input logic [24:0] a);
    return a[16:1] ^ 16'hC35A;
  endfunction

  function automatic logic [15:0] vword(input logic [14:0] w);
    return {w[7:0] ^ 8'h96, w[14:7] + w[7:0]};
  endfunction

  assign vram_rdata_i = vword(vram_raddr_o[15:1]);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    case (en_mode)
      0: en_i <= 1'b1;
      1: en_i <= cyc[0];
      default: en_i <= 1'b0;
    endcase
    if (mem_req_o && !mem_ack_i) begin
      if (lat == 2'd2) begin
        mem_ack_i   <= 1'b1;
        mem_rdata_i <= memf(mem_addr_o);
        lat         <= 0;
      end else lat <= lat + 1;
    end else mem_ack_i <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !p_ack && !mem_req_o) viol++;
      if (mem_req_o && !p_req && !p_en) viol++;
      if (cap_on && wr_o && cap_n < 512) begin
        cap_addr[cap_n] = wr_addr_o;
        cap_data[cap_n] = wr_data_o;
        cap_be[cap_n]   = wr_be_o;
        cap_tgt[cap_n]  = wr_tgt_o;
        cap_ma[cap_n]   = mem_addr_o;
        cap_n++;
      end
    end
    p_req = mem_req_o;
    p_ack = mem_ack_i;
    p_en  = en_i;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog act=%0d exp=<100000", cyc);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int expn(input scen_t s);
    int n;
    if (s.mode == 2'd1) return int'(s.len) + 1;
    if (s.mode == 2'd2 || s.tgt != 2'd1) return int'(s.len);
    n = 0;
    for (int k = 0; k < int'(s.len); k++) begin
      logic [15:0] a;
      a = s.dst + 16'(k) * {8'd0, s.inc};
      if (a > 16'h007F) break;
      n++;
    end
    return n;
  endfunction

  task automatic expw(input scen_t s, input int k, output logic [15:0] a,
                      output logic [15:0] d, output logic [1:0] be,
                      output logic [1:0] tg, output logic [24:0] ma);
    logic [15:0] sa, w;
    logic [7:0] b;
    tg = 2'd0; ma = '0;
    if (s.mode == 2'd1) begin
      b = s.fbyte; d = {b, b};
      if (k == 0) begin
        a = s.dst; be = a[0] ? 2'b01 : 2'b10;  // R7 arming write
      end else begin
        a = s.dst + 16'(k - 1) * {8'd0, s.inc}; be = a[0] ? 2'b10 : 2'b01;
      end
    end else if (s.mode == 2'd2) begin
      sa = s.src_lo + 16'(k); w = vword(sa[15:1]);
      b = sa[0] ? w[7:0] : w[15:8];
      a = s.dst + 16'(k) * {8'd0, s.inc};
      d = {b, b}; be = a[0] ? 2'b01 : 2'b10;
    end else begin
      sa = s.src_lo + 16'(k); ma = {s.src_hi, sa, 1'b0}; w = memf(ma);
      a = s.dst + 16'(k) * {8'd0, s.inc};
      d = (s.tgt == 2'd0 && a[0]) ? {w[7:0], w[15:8]} : w;
      be = 2'b11; tg = s.tgt;
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy_o && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_scen(input scen_t s, input int id);
    int n, m;
    bit ok_a, ok_d, ok_m;
    logic [31:0] aa, ea, ad, ed, am, em;
    string tag;
    @(posedge clk); #1;
    en_mode = s.enm; mode_i = s.mode; tgt_i = s.tgt; src_hi_i = s.src_hi;
    src_lo_i = s.src_lo; len_i = s.len; dst_i = s.dst; inc_i = s.inc;
    cap_n = 0; cap_on = 1; start_i = 1;
    @(posedge clk); #1; start_i = 0;
    @(negedge clk);
    chk(busy_o == (s.mode != 2'd1), "R12", $sformatf("busy after start s%0d", id),
        32'(busy_o), 32'(s.mode != 2'd1));
    if (s.restart) begin
      @(posedge clk); #1;
      mode_i = 2'd1; dst_i = 16'h5555; len_i = 16'd1; start_i = 1;
      @(posedge clk); #1; start_i = 0;
    end
    if (s.mode == 2'd1) begin
      repeat (5) @(negedge clk);
      chk(cap_n == 0 && !busy_o, "R7", $sformatf("fill wait s%0d", id),
          32'(cap_n) | (32'(busy_o) << 16), 0);
      @(posedge clk); #1; dport_byte_i = s.fbyte; dport_we_i = 1;
      @(posedge clk); #1; dport_we_i = 0;
    end
    wait_idle();
    cap_on = 0;
    n = expn(s);
    chk(cap_n == n, "R11", $sformatf("write count s%0d", id), cap_n, n);
    if (s.restart) chk(cap_n == n, "R2", "restart while busy ignored", cap_n, n);
    m = (cap_n < n) ? cap_n : n;
    ok_a = 1; ok_d = 1; ok_m = 1;
    aa = 0; ea = 0; ad = 0; ed = 0; am = 0; em = 0;
    for (int k = 0; k < m; k++) begin
      logic [15:0] a, d; logic [1:0] be, tg; logic [24:0] ma;
      expw(s, k, a, d, be, tg, ma);
      if (ok_a && cap_addr[k] !== a) begin ok_a = 0; aa = cap_addr[k]; ea = a; end
      if (ok_d && {cap_data[k], cap_be[k], cap_tgt[k]} !== {d, be, tg}) begin
        ok_d = 0; ad = {cap_data[k], 6'd0, cap_be[k], 6'd0, cap_tgt[k]};
        ed = {d, 6'd0, be, 6'd0, tg};
      end
      if (ok_m && s.mode == 2'd0 && cap_ma[k] !== ma) begin ok_m = 0; am = cap_ma[k]; em = ma; end
    end
    chk(ok_a, "R10", $sformatf("dest address s%0d", id), aa, ea);
    if (s.mode == 2'd1) tag = "R8";
    else if (s.mode == 2'd2) tag = "R9";
    else if (s.tgt == 2'd1) tag = "R6";
    else tag = "R5";
    chk(ok_d, tag, $sformatf("data/lanes s%0d", id), ad, ed);
    if (s.mode == 2'd0) chk(ok_m, "R3", $sformatf("source address s%0d", id), am, em);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !mem_req_o && !wr_o, "R1", "outputs in reset",
        {busy_o, mem_req_o, wr_o}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(!busy_o, "R1", "busy after reset", busy_o, 0);
    chk(!mem_req_o && !wr_o, "R1", "req/wr after reset", {mem_req_o, wr_o}, 0);

    for (int i = 0; i < NS; i++) run_scen(SCN[i], i);

    // R13: enable held low stalls a copy
    @(posedge clk); #1;
    en_mode = 2; mode_i = 2'd2; src_lo_i = 16'h0010; len_i = 16'd2;
    dst_i = 16'h0600; inc_i = 8'd2; cap_n = 0; cap_on = 1; start_i = 1;
    @(posedge clk); #1; start_i = 0;
    repeat (10) @(negedge clk);
    chk(cap_n == 0, "R13", "no step while disabled", cap_n, 0);
    chk(busy_o, "R12", "busy while stalled", busy_o, 1);
    @(posedge clk); #1; en_mode = 0;
    wait_idle();
    cap_on = 0;
    chk(cap_n == 2, "R13", "steps resume", cap_n, 2);

    // R13: transfer issues no read while disabled
    @(posedge clk); #1;
    en_mode = 2; mode_i = 2'd0; tgt_i = 2'd0; src_lo_i = 16'h0008; len_i = 16'd1;
    dst_i = 16'h0700; start_i = 1;
    @(posedge clk); #1; start_i = 0;
    repeat (6) @(negedge clk);
    chk(!mem_req_o, "R13", "no read while disabled", mem_req_o, 0);
    @(posedge clk); #1; en_mode = 0;
    wait_idle();

    chk(viol == 0, "R4", "request handshake", viol, 0);
    summary();
    $finish;
  end
endmodule